// File: doc/BRIEF.md
# Supply-Loss Write Guard

This block sits between a host's memory strobes and a small battery-backed byte memory and keeps the memory safe while the supply is failing. Two digital monitor flags report whether the supply is below the protect threshold and whether it is below the battery switchover threshold. The block filters both flags and runs a small sequencer. That sequencer decides whether the host's chip-enable, write-enable and output-enable reach the memory. It also decides when the memory runs from the battery.

When the protect flag rises, the block blocks the memory at once if it is idle. If an access is already under way, the block lets it finish, but only up to a protect deadline. On the way back up, the block holds the memory blocked for a recovery period before host traffic is passed again. Before the first power-up, the battery stays disconnected. All delays are counted in ticks of an external strobe, usually one per microsecond.

Top module: `pfail_guard`

## Requirements
- R1: While `rst` is high and after it is released, the block is in the protected state: `state_code` is 2, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, and `bat_sel` is 0.
- R2: `state_code` reports the state as 0 normal, 1 protect pending, 2 protected, 3 on battery, 4 recovering. No other value appears.
- R3: In the normal state, `mem_ce_n`, `mem_we_n` and `mem_oe_n` copy `host_ce_n`, `host_we_n` and `host_oe_n` one clock later.
- R4: A monitor flag (1 means the supply is below that threshold) passes through two synchronizer stages. It is taken only after it differs from the accepted value on FILT_TICKS consecutive ticks, so a pulse shorter than that has no effect. With a tick every clock, a held flag change shows on `state_code` FILT_TICKS+3 clocks after it is applied.
- R5: If the protect flag is taken while `host_ce_n` is 1, the block goes straight from normal to protected.
- R6: If the protect flag is taken while `host_ce_n` is 0, the block enters protect pending and keeps passing the host strobes. On the first clock edge that sees `host_ce_n` at 1, it becomes protected.
- R7: Protect pending lasts at most WP_TICKS ticks. The block then becomes protected, even if `host_ce_n` is still 0.
- R8: In the protected, battery and recovering states, all three memory strobes are 1 whatever the host drives.
- R9: In the protected state, once power has been seen, a taken switchover flag moves the block to the battery state with `bat_sel` at 1. When the switchover flag clears, the block returns to protected with `bat_sel` at 0.
- R10: Until the protect flag has been taken as 0 at least once after reset, `bat_sel` stays 0 even if the switchover flag is set.
- R11: When the protected state sees both flags clear, the block enters recovering. It reaches normal after ER_TICKS further ticks.
- R12: If the protect flag is taken again during recovering, the block returns to protected on the next clock. The next recovery counts a full ER_TICKS again.
- R13: The protect and recovery counts advance only on clocks where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one clock wide |
| vdd_below_prot | input | 1 | Asynchronous flag: supply below protect threshold |
| vdd_below_swo | input | 1 | Asynchronous flag: supply below switchover threshold |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to memory |
| mem_we_n | output | 1 | Gated write enable to memory |
| mem_oe_n | output | 1 | Gated output enable to memory (1 keeps data high-Z) |
| bat_sel | output | 1 | Battery supplies the memory |
| state_code | output | 3 | Sequencer state code |

## Verification
The bench uses a tick on every clock, so every delay becomes a fixed number of clocks. A monitor-flag change shows on `state_code` and the strobes FILT_TICKS+3 clocks after it is driven. A host strobe change shows one clock later in normal or pending. A state then lasts exactly WP_TICKS or ER_TICKS clocks before its exit. Inputs are changed on the falling edge and outputs read on a later falling edge. Each check is placed one clock before and exactly at the edge where its result is due, so an early or late transition is caught. Glitch widths from one tick up to one below the filter length are swept.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_PEND   = 3'd1,
    ST_PROT   = 3'd2,
    ST_BATT   = 3'd3,
    ST_RECOV  = 3'd4
  } pfg_state_e;
endpackage

// File: rtl/pfg_flag_filter.sv
module pfg_flag_filter #(
  parameter int HOLD_TICKS = 4,
  parameter bit RST_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= RST_VAL;
      s2    <= RST_VAL;
      clean <= RST_VAL;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(HOLD_TICKS - 1)) begin
          clean <= s2;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4
  accept_src_chk: assert property (@(posedge clk) disable iff (rst)
    (clean != $past(clean)) |-> (clean == $past(s2)));

  // R4
  hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(HOLD_TICKS));
endmodule

// File: rtl/pfg_seq.sv
module pfg_seq
  import pfg_pkg::*;
#(
  parameter int WP_TICKS = 150,
  parameter int ER_TICKS = 120000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       prot_f,
  input  logic       swo_f,
  input  logic       host_ce_n,
  output pfg_state_e state_q,
  output pfg_state_e state_d
);
  localparam int CMAX = (WP_TICKS > ER_TICKS) ? WP_TICKS : ER_TICKS;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          powered_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: begin
        cnt_d = '0;
        if (prot_f) state_d = host_ce_n ? ST_PROT : ST_PEND;
      end
      ST_PEND: begin
        if (host_ce_n || swo_f) begin
          state_d = ST_PROT;
        end else if (tick) begin
          if (cnt_q == CW'(WP_TICKS - 1)) state_d = ST_PROT;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PROT: begin
        cnt_d = '0;
        if (swo_f) begin
          if (powered_q) state_d = ST_BATT;
        end else if (!prot_f) begin
          state_d = ST_RECOV;
        end
      end
      ST_BATT: begin
        cnt_d = '0;
        if (!swo_f) state_d = ST_PROT;
      end
      ST_RECOV: begin
        if (prot_f) begin
          state_d = ST_PROT;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt_q == CW'(ER_TICKS - 1)) state_d = ST_NORMAL;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_PROT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_PROT;
      cnt_q     <= '0;
      powered_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      powered_q <= powered_q | ~prot_f;
    end
  end

  // R7
  pend_window_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND) |-> (cnt_q < CW'(WP_TICKS)));

  // R12
  refail_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECOV && prot_f) |=> (state_q == ST_PROT));

  // R11
  resume_path_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NORMAL && $past(state_q) != ST_NORMAL) |-> ($past(state_q) == ST_RECOV));

  // R10
  iso_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BATT) |-> powered_q);
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
  import pfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pfg_state_e state_d,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  input  logic       host_oe_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       mem_oe_n,
  output logic       bat_sel
);
  logic pass;
  assign pass = (state_d == ST_NORMAL) || (state_d == ST_PEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      bat_sel  <= 1'b0;
    end else begin
      mem_ce_n <= pass ? host_ce_n : 1'b1;
      mem_we_n <= pass ? host_we_n : 1'b1;
      mem_oe_n <= pass ? host_oe_n : 1'b1;
      bat_sel  <= (state_d == ST_BATT);
    end
  end

  // R9
  bat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bat_sel |-> (mem_ce_n && mem_we_n && mem_oe_n));
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfg_pkg::*;
#(
  parameter int FILT_TICKS = 4,
  parameter int WP_TICKS   = 150,
  parameter int ER_TICKS   = 120000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       vdd_below_prot,
  input  logic       vdd_below_swo,
  input  logic       host_ce_n,
  input  logic       host_we_n,
  input  logic       host_oe_n,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       mem_oe_n,
  output logic       bat_sel,
  output logic [2:0] state_code
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] raw_flags, clean_flags;
  pfg_state_e       state_q, state_d;

  assign raw_flags = {vdd_below_swo, vdd_below_prot};

  for (genvar g = 0; g < NFLAG; g++) begin : g_filt
    pfg_flag_filter #(.HOLD_TICKS(FILT_TICKS), .RST_VAL(1'b1)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .raw  (raw_flags[g]),
      .clean(clean_flags[g])
    );
  end

  pfg_seq #(.WP_TICKS(WP_TICKS), .ER_TICKS(ER_TICKS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .prot_f   (clean_flags[0]),
    .swo_f    (clean_flags[1]),
    .host_ce_n(host_ce_n),
    .state_q  (state_q),
    .state_d  (state_d)
  );

  pfg_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .state_d  (state_d),
    .host_ce_n(host_ce_n),
    .host_we_n(host_we_n),
    .host_oe_n(host_oe_n),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .bat_sel  (bat_sel)
  );

  assign state_code = state_q;

  // R8
  blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd2 || state_code == 3'd3 || state_code == 3'd4)
      |-> (mem_ce_n && mem_we_n && mem_oe_n));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    state_code <= 3'd4);
endmodule

// File: tb/sim_pfail_guard.sv
module sim_pfail_guard;
  localparam int CLK_PERIOD = 10;
  localparam int F   = 3;
  localparam int WP  = 6;
  localparam int ER  = 12;
  localparam int LAT = F + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic dsel = 1'b1, swo = 1'b1;
  logic hce = 1'b1, hwe = 1'b1, hoe = 1'b1;
  logic mce, mwe, moe, bat;
  logic [2:0] code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfail_guard #(.FILT_TICKS(F), .WP_TICKS(WP), .ER_TICKS(ER)) u0 (
    .clk(clk), .rst(rst), .tick(tick),
    .vdd_below_prot(dsel), .vdd_below_swo(swo),
    .host_ce_n(hce), .host_we_n(hwe), .host_oe_n(hoe),
    .mem_ce_n(mce), .mem_we_n(mwe), .mem_oe_n(moe),
    .bat_sel(bat), .state_code(code)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      summary();
    end
  end

  initial begin
    adv(3);
    // R1: state and strobes while held in reset
    chk("R1 code in reset", int'(code), 2);
    chk("R1 strobes in reset", int'({mce, mwe, moe}), 7);
    rst = 1'b0;
    adv(1);
    chk("R1 code after reset", int'(code), 2);
    chk("R1 bat_sel after reset", int'(bat), 0);

    // R10: switchover flag set before any power
    adv(20);
    chk("R10 battery isolated", int'(bat), 0);
    chk("R10 stays protected", int'(code), 2);

    // R4 latency and R11 power-up into recovery
    dsel = 1'b0; swo = 1'b0;
    adv(LAT - 1);
    chk("R4 not yet taken", int'(code), 2);
    adv(1);
    chk("R11 recovering", int'(code), 4);
    hce = 1'b0; hwe = 1'b0; hoe = 1'b0;
    adv(ER - 1);
    chk("R11 still recovering", int'(code), 4);
    chk("R8 host ignored in recovery", int'({mce, mwe, moe}), 7);
    adv(1);
    chk("R11 normal after ER", int'(code), 0);
    chk("R3 pass at entry", int'({mce, mwe, moe}), 0);

    // R3: sweep all strobe combinations
    for (int v = 0; v < 8; v++) begin
      {hce, hwe, hoe} = 3'(v);
      adv(1);
      chk("R3 pass-through", int'({mce, mwe, moe}), v);
    end
    hce = 1'b1; hwe = 1'b1; hoe = 1'b1;

    // R4: glitches shorter than the filter are ignored
    for (int w = 1; w < F; w++) begin
      dsel = 1'b1;
      adv(w);
      dsel = 1'b0;
      adv(LAT + w);
      chk("R4 glitch ignored", int'(code), 0);
    end

    // R5: idle deselect goes straight to protected
    dsel = 1'b1;
    adv(LAT - 1);
    chk("R5 before accept", int'(code), 0);
    adv(1);
    chk("R5 direct protect", int'(code), 2);
    hce = 1'b0; hwe = 1'b0; hoe = 1'b0;
    adv(3);
    chk("R8 host ignored when protected", int'({mce, mwe, moe}), 7);

    // R9: battery switchover and back
    swo = 1'b1;
    adv(LAT);
    chk("R9 battery state", int'(code), 3);
    chk("R9 bat_sel high", int'(bat), 1);
    chk("R8 blocked on battery", int'({mce, mwe, moe}), 7);
    swo = 1'b0;
    adv(LAT);
    chk("R9 back to protected", int'(code), 2);
    chk("R9 bat_sel low", int'(bat), 0);

    // R12: refail during recovery restarts the count
    hce = 1'b1; hwe = 1'b1; hoe = 1'b1;
    dsel = 1'b0;
    adv(LAT);
    chk("R12 recovering", int'(code), 4);
    adv(5);
    dsel = 1'b1;
    adv(LAT);
    chk("R12 refail protects", int'(code), 2);
    dsel = 1'b0;
    adv(LAT);
    chk("R12 recovering again", int'(code), 4);
    adv(ER - 1);
    chk("R12 full count restarted", int'(code), 4);
    adv(1);
    chk("R12 normal after restart", int'(code), 0);

    // R6: access in progress finishes
    hce = 1'b0; hwe = 1'b0; hoe = 1'b1;
    adv(1);
    dsel = 1'b1;
    adv(LAT);
    chk("R6 pending", int'(code), 1);
    chk("R6 write still passed", int'({mce, mwe}), 0);
    hce = 1'b1; hwe = 1'b1;
    adv(1);
    chk("R6 protected after access end", int'(code), 2);
    chk("R6 ce blocked", int'(mce), 1);

    dsel = 1'b0;
    adv(LAT + ER);
    chk("R11 normal again", int'(code), 0);

    // R7: deadline forces protection
    hce = 1'b0;
    adv(1);
    dsel = 1'b1;
    adv(LAT);
    chk("R7 pending", int'(code), 1);
    adv(WP - 1);
    chk("R7 pending before deadline", int'(code), 1);
    chk("R7 ce passed before deadline", int'(mce), 0);
    adv(1);
    chk("R7 forced protect", int'(code), 2);
    chk("R7 ce blocked", int'(mce), 1);

    // R13: counting stalls without ticks
    dsel = 1'b0;
    adv(LAT);
    chk("R13 recovering", int'(code), 4);
    tick = 1'b0;
    adv(3 * ER);
    chk("R13 no progress without tick", int'(code), 4);
    tick = 1'b1;
    adv(ER - 1);
    chk("R13 still recovering", int'(code), 4);
    adv(1);
    chk("R13 normal after ticks", int'(code), 0);
    chk("R3 held access passes", int'(mce), 0);

    done = 1'b1;
    summary();
  end
endmodule